// File: doc/BRIEF.md
# Protected Power-of-Two Clock Prescaler

This block slows the clock seen by a CPU and its synchronous peripherals by a power-of-two factor from 1 to 256. Its counter runs on the fast undivided clock. It presents the divided clock as `clk_en`, a single-cycle enable pulse that the downstream register stages qualify their updates with. Each pulse counts as one active edge of the slow clock. Because every pulse comes from a flop in the fast domain, the slow clock has no combinational path that could glitch.

Software changes the division through one byte-wide control register, and the change is protected. Bit 7 is the change-enable key. A write of exactly 0x80 opens a four-cycle window. A second write with bit 7 at zero must arrive inside that window, and it carries the new code in bits 3:0. Any other write leaves the setting alone. The caller must mask interrupts so that the two writes are not split apart.

A new code does not take effect at once. It waits for the end of the period that is running at the old setting, so every gap between pulses is a whole period of either the old or the new ratio.

Top module: `clk_prescaler`

## Requirements
- R1: After reset the read value is 0x00, meaning code 0 (divide by 1) with the key bit clear. `clk_en` is high on every input cycle from the first edge after reset is released.
- R2: With code c in 0..8 applied, `clk_en` pulses once every 2^c input cycles. For c > 0 each pulse is exactly one cycle wide.
- R3: A write of exactly 0x80 sets bit 7 of `rd_data` from the next cycle on, and leaves bits 3:0 unchanged.
- R4: A write with bit 7 set and any of bits 6:0 nonzero does not open the window.
- R5: The window is open on the four clock edges that follow the unlocking edge. A write with bit 7 clear on any of those edges loads its bits 3:0 as the new code, which is read back in `rd_data[3:0]`, and closes the window.
- R6: If no write lands on those four edges, bit 7 clears by itself after the fourth edge. A code written later is ignored.
- R7: A code write with bit 7 clear and no open window leaves the code and the output period unchanged.
- R8: A second write that carries a reserved code (9 to 15) leaves the setting unchanged and still closes the window.
- R9: During a switch, every gap between `clk_en` pulses equals either the old or the new period, and no gap at the old period follows a gap at the new period.
- R10: A new code is applied at the first boundary of the old period after the request. All gaps from then on are at the new period.
- R11: `rd_data` bits 6:4 always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Undivided fast clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Write data: bit 7 key, bits 3:0 code |
| rd_data | output | 8 | Read value: bit 7 window open, bits 3:0 current code |
| clk_en | output | 1 | Registered divided-clock enable pulse |

## Verification
The in-line properties assume three things. Reset is held across at least one rising edge before operation starts. `wr_data` is valid whenever `wr_en` is high. No third party inserts a write between the two steps of an unlock, which the caller guarantees by masking interrupts.

The stimulus changes `wr_en` and `wr_data` only on falling edges, one write per cycle. It reads the outputs on falling edges, so each write is captured on exactly one rising edge. This keeps the boundary cases on the fourth and fifth edges after unlock unambiguous.

// File: rtl/clk_prescaler_pkg.sv
package clk_prescaler_pkg;
  localparam int CODE_W = 4;

  typedef struct packed {
    logic              valid;
    logic [CODE_W-1:0] code;
  } ratio_req_t;
endpackage

// File: rtl/unlock_ctrl.sv
module unlock_ctrl
  import clk_prescaler_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int MAX_CODE = 8,
  parameter int WINDOW   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output ratio_req_t        req
);
  localparam int WIN_W   = $clog2(WINDOW + 1);
  localparam int KEY_BIT = DATA_W - 1;
  localparam int PAD_W   = DATA_W - 1 - CODE_W;

  logic [WIN_W-1:0]  win_cnt;
  logic [CODE_W-1:0] code_q;
  logic              win_open;
  logic              unlock_hit;
  logic              second_hit;
  logic              code_ok;

  assign win_open   = (win_cnt != '0);
  assign unlock_hit = wr_en && wr_data[KEY_BIT] && (wr_data[KEY_BIT-1:0] == '0);
  assign second_hit = wr_en && !wr_data[KEY_BIT] && win_open;
  assign code_ok    = (int'(wr_data[CODE_W-1:0]) <= MAX_CODE);

  always_ff @(posedge clk) begin
    if (rst) begin
      win_cnt   <= '0;
      code_q    <= '0;
      req.valid <= 1'b0;
      req.code  <= '0;
    end else begin
      req.valid <= 1'b0;
      if (unlock_hit) begin
        win_cnt <= WIN_W'(WINDOW);
      end else if (second_hit) begin
        win_cnt <= '0;
        if (code_ok) begin
          code_q    <= wr_data[CODE_W-1:0];
          req.valid <= 1'b1;
          req.code  <= wr_data[CODE_W-1:0];
        end
      end else if (win_open) begin
        win_cnt <= win_cnt - WIN_W'(1);
      end
    end
  end

  assign rd_data = {win_open, {PAD_W{1'b0}}, code_q};

  // R3: the exact key value opens the window on the next cycle
  a_r3_key_opens: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data == {1'b1, {(DATA_W-1){1'b0}}}) |=> win_open);

  // R7: with the window closed the stored code cannot move
  a_r7_closed_holds: assert property (@(posedge clk) disable iff (rst)
    !win_open |=> $stable(code_q));

  // R8: a reserved code keeps the setting and shuts the window
  a_r8_reserved_kept: assert property (@(posedge clk) disable iff (rst)
    (win_open && wr_en && !wr_data[KEY_BIT] && int'(wr_data[CODE_W-1:0]) > MAX_CODE)
      |=> ($stable(code_q) && !win_open));

  // R5: a request is a one-cycle event
  a_r5_req_single: assert property (@(posedge clk) disable iff (rst)
    req.valid |=> !req.valid);
endmodule

// File: rtl/div_counter.sv
module div_counter
  import clk_prescaler_pkg::*;
#(
  parameter int MAX_CODE = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  ratio_req_t req,
  output logic       clk_en
);
  localparam int CNT_W = (MAX_CODE > 0) ? MAX_CODE : 1;

  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  lim;
  logic [CODE_W-1:0] cur_code;
  logic [CODE_W-1:0] pend_code;
  logic              pend_valid;
  logic              tick_now;

  // period limit as a thermometer of the applied code
  for (genvar gi = 0; gi < CNT_W; gi++) begin : g_lim
    assign lim[gi] = (int'(cur_code) > gi);
  end

  assign tick_now = (cnt == lim);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt        <= '0;
      cur_code   <= '0;
      pend_code  <= '0;
      pend_valid <= 1'b0;
      clk_en     <= 1'b0;
    end else begin
      clk_en <= tick_now;
      if (tick_now) cnt <= '0;
      else          cnt <= cnt + CNT_W'(1);
      if (tick_now && pend_valid) cur_code <= pend_code;
      if (req.valid) begin
        pend_valid <= 1'b1;
        pend_code  <= req.code;
      end else if (tick_now) begin
        pend_valid <= 1'b0;
      end
    end
  end

  // R10: the ratio changes only on a period boundary
  a_r10_switch_on_boundary: assert property (@(posedge clk) disable iff (rst)
    !tick_now |=> $stable(cur_code));

  // R2: pulses are isolated when dividing
  a_r2_pulse_width: assert property (@(posedge clk) disable iff (rst)
    (clk_en && cur_code != '0) |=> !clk_en);

  // R9: a fresh period starts at zero after each pulse
  a_r9_restart_after_tick: assert property (@(posedge clk) disable iff (rst)
    tick_now |=> (cnt == '0));
endmodule

// File: rtl/clk_prescaler.sv
module clk_prescaler
  import clk_prescaler_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int MAX_CODE = 8,
  parameter int WINDOW   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              clk_en
);
  ratio_req_t req;

  unlock_ctrl #(
    .DATA_W  (DATA_W),
    .MAX_CODE(MAX_CODE),
    .WINDOW  (WINDOW)
  ) u_unlock (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .wr_data(wr_data),
    .rd_data(rd_data),
    .req    (req)
  );

  div_counter #(
    .MAX_CODE(MAX_CODE)
  ) u_div (
    .clk   (clk),
    .rst   (rst),
    .req   (req),
    .clk_en(clk_en)
  );

  // R11: padding bits of the read value stay zero
  a_r11_pad_zero: assert property (@(posedge clk) disable iff (rst)
    rd_data[DATA_W-2:CODE_W] == '0);
endmodule

// File: tb/clk_prescaler_test.sv
module clk_prescaler_test;
  localparam int PERIOD = 10;
  localparam int NVEC = 8;
  // high nibble: code written, low nibble: code expected afterwards
  localparam logic [7:0] VECS [NVEC] = '{8'h33, 8'h00, 8'h88, 8'h11,
                                         8'hC1, 8'h55, 8'hF5, 8'h22};

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       clk_en;
  int checks = 0;
  int fails = 0;

  always #(PERIOD/2) clk = ~clk;

  clk_prescaler uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .clk_en(clk_en)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // called at a falling edge; the write lands on the next rising edge
  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    wr_data = 8'h00;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic next_gap(output int g);
    while (!clk_en) @(negedge clk);
    g = 0;
    do begin
      @(negedge clk);
      g++;
    end while (!clk_en);
  endtask

  task automatic switch_check(input string req, input int old_p, input int new_p);
    int  g;
    bit  seen_new = 1'b0;
    for (int i = 0; i < 6; i++) begin
      next_gap(g);
      if (g == new_p) seen_new = 1'b1;
      chk(req, int'(g == old_p || g == new_p), 1);
      if (seen_new) chk(req, g, new_p);
    end
    chk(req, g, new_p);
  endtask

  initial begin
    #(PERIOD * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int g;
    idle(3);
    rst = 1'b0;
    chk("R1 read after reset", int'(rd_data), 0);
    @(negedge clk);
    chk("R1 enable cycle 1", int'(clk_en), 1);
    @(negedge clk);
    chk("R1 enable cycle 2", int'(clk_en), 1);

    // vector table: unlock, write, then steady period
    for (int i = 0; i < NVEC; i++) begin
      wr(8'h80);
      wr({4'h0, VECS[i][7:4]});
      chk((VECS[i][7:4] > 8) ? "R8 code kept" : "R5 code loaded",
          int'(rd_data[3:0]), int'(VECS[i][3:0]));
      chk("R5 window closed", int'(rd_data[7]), 0);
      chk("R11 pad bits", int'(rd_data[6:4]), 0);
      next_gap(g);
      next_gap(g);
      next_gap(g);
      chk("R2 period", g, 1 << VECS[i][3:0]);
      next_gap(g);
      chk("R2 period", g, 1 << VECS[i][3:0]);
    end

    // R2: pulse width with code 2
    while (!clk_en) @(negedge clk);
    @(negedge clk);
    chk("R2 pulse width", int'(clk_en), 0);

    // R7: write with no window
    wr(8'h05);
    chk("R7 code unchanged", int'(rd_data[3:0]), 2);
    next_gap(g);
    next_gap(g);
    chk("R7 period unchanged", g, 4);

    // R4: malformed key
    wr(8'h81);
    chk("R4 window stays shut", int'(rd_data[7]), 0);
    wr(8'h05);
    chk("R4 code unchanged", int'(rd_data[3:0]), 2);

    // R3 / R5: key opens, write on the fourth edge is accepted
    wr(8'h80);
    chk("R3 window open", int'(rd_data[7]), 1);
    chk("R3 code kept", int'(rd_data[3:0]), 2);
    idle(3);
    chk("R5 window open at edge 3", int'(rd_data[7]), 1);
    wr(8'h06);
    chk("R5 fourth edge write", int'(rd_data), 6);

    // R6: window lapses, fifth-edge write ignored
    wr(8'h80);
    idle(4);
    chk("R6 window lapsed", int'(rd_data[7]), 0);
    wr(8'h01);
    chk("R6 late write ignored", int'(rd_data[3:0]), 6);
    next_gap(g);
    next_gap(g);
    chk("R6 period unchanged", g, 64);

    // R9 / R10: slow-down then speed-up switches
    wr(8'h80);
    wr(8'h08);
    switch_check("R9 R10 64->256", 64, 256);
    wr(8'h80);
    wr(8'h01);
    switch_check("R9 R10 256->2", 256, 2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule